// File: doc/BRIEF.md
# Dual-Port Buffered Load and Deferred Store Arbiter

This block shares one single-port data memory between two vector load ports and a store path. Each load asks for 16 consecutive bytes starting at any byte address. Each load port keeps a 32-byte window of memory. A request that falls wholly inside that window is answered from the window and leaves the memory idle. A request that falls outside triggers one memory access, which reads two adjacent 16-byte rows and refills the window.

Stores arrive as whole 16-byte rows, up to two per cycle. They are parked in a small in-order queue. The queue writes them back one per cycle, in cycles where no refill read needs the memory. When the two loads, the queue or an address overlap need more memory slots than one cycle offers, a single `stall` output freezes every upstream stage. The upstream stages must then present the same requests again in the next cycle.

The memory port reads with one cycle of latency. `mem_rdata[127:0]` returns row `mem_row` and `mem_rdata[255:128]` returns the row after it, with the row index wrapping at the top of memory. `QDEPTH` must be a power of two and at least 2.

Top module: `ldst_buf_arb`

## Requirements
- R1: After reset, both windows are empty, the queue holds nothing, and `stall`, `ld0_dv`, `ld1_dv` and `mem_en` are all low while no request is presented.
- R2: A load at address `a` whose port window begins at base `b` is a hit when `(a - b) mod 2^AW` lies in 0..16. A hit causes no memory read. In the next cycle its port presents the 16 bytes with `dv` high.
- R3: A load that misses reads row `a>>4` and the following row (wrapping) in the same cycle, and sets its window base to `a` rounded down to 16. In the next cycle it presents the data. Byte k of the 16-byte result sits in bits `[8k+7:8k]` and equals memory byte `(a+k) mod 2^AW`.
- R4: At most one memory access happens per cycle. When both ports miss together, port 0 refills first with `stall` high, and port 1 refills in the following cycle.
- R5: In a cycle with `stall` high nothing is accepted. `ld0_dv` and `ld1_dv` are low in the next cycle, and the held requests complete once `stall` falls.
- R6: Up to two store rows are accepted per cycle, and `st0` counts as older than `st1`. Queued rows are written oldest first, one per cycle, and only in cycles without a refill read.
- R7: When queue occupancy plus the stores presented exceeds `QDEPTH`, `stall` is high and the oldest entry is written in that cycle.
- R8: If a missing load's two rows include a queued store row, the queue drains with `stall` high until no such row remains. The refill then returns the stored data.
- R9: Two ports that miss together and then hit together for k requests finish k+1 requests in k+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld0_valid | input | 1 | Port 0 load request |
| ld0_addr | input | AW | Port 0 start byte address |
| ld1_valid | input | 1 | Port 1 load request |
| ld1_addr | input | AW | Port 1 start byte address |
| st0_valid | input | 1 | Older store request |
| st0_row | input | AW-4 | Older store row index |
| st0_data | input | 128 | Older store data |
| st1_valid | input | 1 | Younger store request |
| st1_row | input | AW-4 | Younger store row index |
| st1_data | input | 128 | Younger store data |
| stall | output | 1 | Freeze upstream; requests of this cycle are not taken |
| ld0_dv | output | 1 | Port 0 data valid |
| ld0_data | output | 128 | Port 0 load data |
| ld1_dv | output | 1 | Port 1 data valid |
| ld1_data | output | 128 | Port 1 load data |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_row | output | AW-4 | Row index of the access |
| mem_wdata | output | 128 | Write data |
| mem_rdata | input | 256 | Two rows returned one cycle after a read |

## Verification
The bench builds the block with `AW=10` and `QDEPTH=2`. The 1 KiB memory then fits in a bench-side golden array. Every start offset 0..15 can be swept against every window distance from -3 to 20, which covers both edges of the hit window on both ports, and addresses near 0x3F0 exercise the row wrap. With a two-entry queue, the full-queue stall appears after one pair of stores, and an overlap that must drain two entries before a refill can be set up in a few cycles.

// File: rtl/ldst_buf_arb.sv
module ldst_buf_arb #(
  parameter int AW     = 12,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld0_valid,
  input  logic [AW-1:0]     ld0_addr,
  input  logic              ld1_valid,
  input  logic [AW-1:0]     ld1_addr,
  input  logic              st0_valid,
  input  logic [AW-5:0]     st0_row,
  input  logic [127:0]      st0_data,
  input  logic              st1_valid,
  input  logic [AW-5:0]     st1_row,
  input  logic [127:0]      st1_data,
  output logic              stall,
  output logic              ld0_dv,
  output logic [127:0]      ld0_data,
  output logic              ld1_dv,
  output logic [127:0]      ld1_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-5:0]     mem_row,
  output logic [127:0]      mem_wdata,
  input  logic [255:0]      mem_rdata
);
  localparam int RW = AW - 4;
  localparam int PW = $clog2(QDEPTH);
  localparam int CW = $clog2(QDEPTH + 1);
  localparam int NW = CW + 1;

  logic [1:0]    bvalid, pend, dv, lv, miss, ovl, rdv;
  logic [RW-1:0] brow [2];
  logic [255:0]  bdata [2];
  logic [4:0]    off [2];
  logic [AW-1:0] la [2];
  logic [AW-1:0] diff [2];
  logic [127:0]  data [2];
  logic [RW-1:0] q_row [QDEPTH];
  logic [127:0]  q_dat [QDEPTH];
  logic [PW-1:0] head, tail0, tail1;
  logic [CW-1:0] count;
  logic [NW-1:0] need;
  logic          qfull, drain_first, rd0, rd1, wr, acc;

  assign lv    = {ld1_valid, ld0_valid};
  assign la[0] = ld0_addr;
  assign la[1] = ld1_addr;

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [QDEPTH-1:0] hitq;
    logic [255:0]      src;
    assign diff[p] = la[p] - {brow[p], 4'b0000};
    assign miss[p] = lv[p] && !(bvalid[p] && diff[p] <= AW'(16));
    for (genvar e = 0; e < QDEPTH; e++) begin : g_ent
      logic [PW-1:0] slot;
      assign slot    = head + PW'(e);
      assign hitq[e] = (CW'(e) < count) &&
                       (q_row[slot] == la[p][AW-1:4] || q_row[slot] == la[p][AW-1:4] + RW'(1));
    end
    assign ovl[p]  = miss[p] && |hitq;
    assign src     = pend[p] ? mem_rdata : bdata[p];
    assign data[p] = src[{off[p], 3'b000} +: 128];
  end

  assign need        = NW'(count) + NW'(st0_valid) + NW'(st1_valid);
  assign qfull       = need > NW'(QDEPTH);
  assign drain_first = (|ovl) || qfull;
  assign stall       = drain_first || (miss[0] && miss[1]);
  assign acc         = !stall;
  assign wr          = (count != '0) && (drain_first || !(miss[0] || miss[1]));
  assign rd0         = !drain_first && miss[0];
  assign rd1         = !drain_first && miss[1] && !miss[0];
  assign rdv         = {rd1, rd0};

  assign mem_en    = wr || rd0 || rd1;
  assign mem_we    = wr;
  assign mem_row   = wr ? q_row[head] : (rd0 ? la[0][AW-1:4] : la[1][AW-1:4]);
  assign mem_wdata = q_dat[head];

  assign tail0 = head + PW'(count);
  assign tail1 = tail0 + PW'(st0_valid);

  assign ld0_dv   = dv[0];
  assign ld1_dv   = dv[1];
  assign ld0_data = data[0];
  assign ld1_data = data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bvalid <= '0;
      pend   <= '0;
      dv     <= '0;
      head   <= '0;
      count  <= '0;
    end else begin
      pend   <= rdv;
      dv     <= acc ? lv : 2'b00;
      bvalid <= bvalid | rdv;
      head   <= head + PW'(wr);
      count  <= count + (acc ? CW'(st0_valid) + CW'(st1_valid) : CW'(0)) - CW'(wr);
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (pend[p]) bdata[p] <= mem_rdata;
      if (rdv[p])  brow[p]  <= la[p][AW-1:4];
      if (acc)     off[p]   <= rdv[p] ? {1'b0, la[p][3:0]} : diff[p][4:0];
    end
    if (acc && st0_valid) begin
      q_row[tail0] <= st0_row;
      q_dat[tail0] <= st0_data;
    end
    if (acc && st1_valid) begin
      q_row[tail1] <= st1_row;
      q_dat[tail1] <= st1_data;
    end
  end

  a_r4_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd0, rd1, wr}));
  a_r4_pair_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (miss[0] && miss[1]) |-> stall);
  a_r2_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss[0] && !miss[1]) |-> !(mem_en && !mem_we));
  a_r3_refill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && rd0) |=> (!$stable(ld0_addr) || !ld0_valid || !miss[0]));
  a_r6_drain_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0 && !ld0_valid && !ld1_valid && !st0_valid && !st1_valid)
      |=> (count == $past(count) - CW'(1)));
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(QDEPTH));
  a_r8_drain_before_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovl) |-> (mem_en && mem_we && stall));
endmodule

// File: tb/ldst_buf_arb_test.sv
module ldst_buf_arb_test;
  localparam int AW = 10, QD = 2, NB = 1 << AW, NR = NB / 16, RW = AW - 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic ld0_valid = 0, ld1_valid = 0, st0_valid = 0, st1_valid = 0;
  logic [AW-1:0] ld0_addr = '0, ld1_addr = '0;
  logic [RW-1:0] st0_row = '0, st1_row = '0;
  logic [127:0] st0_data = '0, st1_data = '0;
  logic stall, ld0_dv, ld1_dv, mem_en, mem_we;
  logic [127:0] ld0_data, ld1_data, mem_wdata;
  logic [RW-1:0] mem_row;
  logic [255:0] mem_rdata;

  ldst_buf_arb #(.AW(AW), .QDEPTH(QD)) uut (
    .clk(clk), .rst_n(rst_n),
    .ld0_valid(ld0_valid), .ld0_addr(ld0_addr), .ld1_valid(ld1_valid), .ld1_addr(ld1_addr),
    .st0_valid(st0_valid), .st0_row(st0_row), .st0_data(st0_data),
    .st1_valid(st1_valid), .st1_row(st1_row), .st1_data(st1_data),
    .stall(stall), .ld0_dv(ld0_dv), .ld0_data(ld0_data), .ld1_dv(ld1_dv), .ld1_data(ld1_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_row(mem_row), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata));

  logic [127:0] mem [NR];
  logic [7:0]   gm [NB];
  int rd_cnt = 0, wr_cnt = 0, errors = 0, checks = 0;
  bit mv [2];
  int mb [2];

  always @(posedge clk) if (mem_en) begin
    if (mem_we) begin mem[mem_row] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
    else begin mem_rdata <= {mem[RW'(mem_row + 1)], mem[mem_row]}; rd_cnt <= rd_cnt + 1; end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [127:0] exp16(input int a);
    logic [127:0] r;
    for (int k = 0; k < 16; k++) r[8*k +: 8] = gm[(a + k) % NB];
    return r;
  endfunction

  function automatic bit mmiss(input int p, input int a);
    return !(mv[p] && (((a - mb[p]) % NB + NB) % NB) <= 16);
  endfunction

  function automatic logic [127:0] mk(input int row, input int salt);
    return {4{8'(row), 8'(salt), 16'h5A3C}};
  endfunction

  task automatic put16(input int row, input logic [127:0] d);
    for (int k = 0; k < 16; k++) gm[row * 16 + k] = d[8*k +: 8];
  endtask

  task automatic step(input bit v0, input int a0, input bit v1, input int a1,
                      input bit s0, input int r0, input logic [127:0] d0,
                      input bit s1, input int r1, input logic [127:0] d1,
                      input int exp_cyc, input string tag);
    bit m0, m1;
    bit st;
    int cyc, rd0c, ec;
    logic [127:0] e0, e1;
    m0 = v0 && mmiss(0, a0);
    m1 = v1 && mmiss(1, a1);
    e0 = exp16(a0);
    e1 = exp16(a1);
    ec = (exp_cyc < 0) ? 1 + int'(m0 && m1) : exp_cyc;
    rd0c = rd_cnt;
    ld0_valid = v0; ld0_addr = AW'(a0); ld1_valid = v1; ld1_addr = AW'(a1);
    st0_valid = s0; st0_row = RW'(r0); st0_data = d0;
    st1_valid = s1; st1_row = RW'(r1); st1_data = d1;
    cyc = 0;
    do begin
      #1 st = stall;
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end while (st && cyc < 50);
    chk(cyc == ec, tag, "cycles", 128'(cyc), 128'(ec));
    chk(rd_cnt - rd0c == int'(m0) + int'(m1), tag, "reads", 128'(rd_cnt - rd0c), 128'(int'(m0) + int'(m1)));
    if (v0) chk(ld0_dv && ld0_data == e0, tag, "port0 data", ld0_data, e0);
    else    chk(!ld0_dv, tag, "port0 dv", 128'(ld0_dv), 128'(0));
    if (v1) chk(ld1_dv && ld1_data == e1, tag, "port1 data", ld1_data, e1);
    if (m0) begin mv[0] = 1; mb[0] = a0 & ~15; end
    if (m1) begin mv[1] = 1; mb[1] = a1 & ~15; end
    if (s0) put16(r0, d0);
    if (s1) put16(r1, d1);
    ld0_valid = 0; ld1_valid = 0; st0_valid = 0; st1_valid = 0;
  endtask

  task automatic ld(input bit v0, input int a0, input bit v1, input int a1, input string tag);
    step(v0, a0, v1, a1, 0, 0, '0, 0, 0, '0, -1, tag);
  endtask

  task automatic watch(input bit en, input bit we, input int row, input string tag);
    #1;
    chk(mem_en == en && (!en || (mem_we == we && int'(mem_row) == row)), tag, "memory access",
        {mem_en, mem_we, 120'(mem_row)}, {en, we, 120'(row)});
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int tot, n;
    for (int i = 0; i < NB; i++) gm[i] = 8'(i * 7 + 3);
    for (int r = 0; r < NR; r++) for (int k = 0; k < 16; k++) mem[r][8*k +: 8] = gm[r * 16 + k];
    mv[0] = 0; mv[1] = 0; mb[0] = 0; mb[1] = 0;
    repeat (3) @(negedge clk);
    chk(!stall && !ld0_dv && !ld1_dv && !mem_en, "R1", "reset outputs",
        {stall, ld0_dv, ld1_dv, mem_en}, '0);
    rst_n = 1;
    watch(0, 0, 0, "R1");

    // R2 R3: exhaustive window edges on both ports
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 16; s++)
        for (int d = -3; d <= 20; d++) begin
          int x;
          x = 'h100 + s;
          if (p == 0) begin ld(1, x ^ 'h200, 0, 0, "R3"); ld(1, x, 0, 0, "R3"); ld(1, x + d, 0, 0, "R2 R3"); end
          else begin ld(0, 0, 1, x ^ 'h200, "R3"); ld(0, 0, 1, x, "R3"); ld(0, 0, 1, x + d, "R2 R3"); end
        end

    // R3: wrap at the top row
    for (int a = 'h3E8; a < 'h400; a++) begin
      ld(1, 'h040, 1, 'h140, "R3");
      ld(1, a, 1, a ^ 'h200, "R3 wrap");
    end

    // R4 R5: both miss, inspected cycle by cycle
    ld(1, 'h3E0, 1, 'h1E0, "R4");
    ld0_valid = 1; ld0_addr = 'h0C6; ld1_valid = 1; ld1_addr = 'h2C6;
    #1 chk(stall && mem_en && !mem_we && mem_row == RW'('h0C), "R4", "port0 first with stall",
           {stall, mem_en, mem_we, 120'(mem_row)}, {1'b1, 1'b1, 1'b0, 120'('h0C)});
    @(posedge clk); @(negedge clk);
    chk(!ld0_dv && !ld1_dv, "R5", "no data after stall", {ld0_dv, ld1_dv}, '0);
    #1 chk(!stall && mem_en && !mem_we && mem_row == RW'('h2C), "R4", "port1 next",
           {stall, mem_en, mem_we, 120'(mem_row)}, {1'b0, 1'b1, 1'b0, 120'('h2C)});
    @(posedge clk); @(negedge clk);
    chk(ld0_dv && ld0_data == exp16('h0C6), "R5", "port0 after stall", ld0_data, exp16('h0C6));
    chk(ld1_dv && ld1_data == exp16('h2C6), "R5", "port1 after stall", ld1_data, exp16('h2C6));
    mv[0] = 1; mb[0] = 'h0C0; mv[1] = 1; mb[1] = 'h2C0;
    ld0_valid = 0; ld1_valid = 0;

    // R9: groups of three iterations, both ports in step
    ld(1, 'h000, 1, 'h200, "R9");
    n = 13; tot = 0;
    for (int i = 0; i < n; i++) begin
      int a, t0;
      a = 16 * (i / 3) + 2 * (i % 3);
      t0 = $time;
      ld(1, 'h100 + a, 1, 'h300 + a, "R9");
      tot += (int'($time) - t0) / 10;
    end
    chk(tot == n + 1 + (n - 2) / 3, "R9", "group cycles", 128'(tot), 128'(n + 1 + (n - 2) / 3));

    // R6: two stores per cycle, oldest first, same row younger wins
    ld(1, 'h000, 1, 'h000, "R6");
    step(0, 0, 0, 0, 1, 'h30, mk('h30, 1), 1, 'h31, mk('h31, 1), 1, "R6");
    watch(1, 1, 'h30, "R6");
    watch(1, 1, 'h31, "R6");
    watch(0, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 'h3A, mk('h3A, 1), 1, 'h3A, mk('h3A, 2), 1, "R6");
    watch(1, 1, 'h3A, "R6");
    watch(1, 1, 'h3A, "R6");
    // R6: writes wait while refills use the memory
    step(1, 'h040, 0, 0, 1, 'h32, mk('h32, 3), 1, 'h33, mk('h33, 3), 1, "R6");
    begin
      int w0;
      w0 = wr_cnt;
      ld(1, 'h080, 0, 0, "R6");
      chk(wr_cnt == w0, "R6", "no write during refill", 128'(wr_cnt - w0), '0);
    end
    watch(1, 1, 'h32, "R6");
    watch(1, 1, 'h33, "R6");

    // R7: queue full
    step(0, 0, 0, 0, 1, 'h34, mk('h34, 4), 1, 'h35, mk('h35, 4), 1, "R7");
    step(0, 0, 0, 0, 1, 'h36, mk('h36, 4), 1, 'h37, mk('h37, 4), 3, "R7");
    watch(1, 1, 'h36, "R7");
    watch(1, 1, 'h37, "R7");

    // R8: overlap drains before refill
    step(0, 0, 0, 0, 1, 'h38, mk('h38, 5), 0, 0, '0, 1, "R8");
    step(1, 'h37A, 0, 0, 0, 0, '0, 0, 0, '0, 2, "R8");
    step(0, 0, 0, 0, 1, 'h10, mk('h10, 6), 1, 'h11, mk('h11, 6), 1, "R8");
    step(0, 0, 1, 'h118, 0, 0, '0, 0, 0, '0, 3, "R8");

    // R6 R7: stored rows read back through fresh refills
    for (int r = 'h30; r <= 'h3A; r++) begin
      ld(1, 'h000, 1, 'h000, "R6");
      ld(1, r * 16, 1, r * 16 + 3, "R6 R7 readback");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule